// File: doc/BRIEF.md
# LCD Segment and Common Scan Controller

This block holds the on/off state of every pixel of a small multiplexed LCD panel and scans it out one common phase at a time. The pixel store has one 4-bit word per segment line, 32 segments in all. Bit k of a segment's word is the pixel where that segment crosses common k. A CPU-side write port addresses these words by a row number and a column number. Writing a 1 to a bit lights the pixel with no further command.

An external LCD clock tick, one cycle wide, advances the active common. The duty 1/n can be set to n = 1, 2, 3 or 4. The common counter steps through 0 .. n-1 and then wraps to 0, so one frame is n ticks long. The block drives one-hot common strobes. For each segment it drives a digital level that gives the stored pixel for the active common. Bias voltages and drive waveform inversion are left to the analog output stage.

Top module: `lcd_scan_top`

## Requirements
- R1: After reset all pixel bits are 0, the common index is 0, `comOut` is 4'b0001 and `segOut` is all 0.
- R2: A write with `wrRow` in 12..15 and `wrCol` in 8..15 stores `wrData` for segment (wrRow-12)*8 + (wrCol-8). Bit k of `wrData` is the pixel for common k.
- R3: A stored write is visible on `segOut` from the clock edge that takes it. Segment s shows bit `comIdx` of its word, with no tick needed.
- R4: A write whose row is outside 12..15 or whose column is outside 8..15 changes no pixel.
- R5: On an edge with `lcdTick` high, the common index becomes 0 if it is at or above `dutySel`. Otherwise it goes up by 1. The duty is n = `dutySel`+1.
- R6: On an edge without `lcdTick`, the common index holds.
- R7: `comOut` has bit `comIdx` set, and only that bit, when `comIdx` < n. It is all zero when `comIdx` >= n, which can happen after the duty is lowered. `segOut` still shows bit `comIdx` in that case.
- R8: `segOut` changes on the same edge as `comOut` and shows the pixels of the new common.
- R9: With a fixed duty n, the `comOut` sequence repeats every n ticks, so the frame rate is the tick rate divided by n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lcdTick | input | 1 | One-cycle LCD clock tick that advances the common |
| dutySel | input | 2 | Duty select; n = dutySel + 1 |
| wrEn | input | 1 | Pixel word write enable |
| wrRow | input | 4 | Write row address (valid 12..15) |
| wrCol | input | 4 | Write column address (valid 8..15) |
| wrData | input | 4 | Pixel word; bit k = common k |
| comOut | output | 4 | One-hot common strobes |
| segOut | output | 32 | Segment on/off levels for the active common |

## Verification
Every result is due one clock edge after its stimulus. This holds for a write, including an ignored one, for a tick, and for a duty change that leaves the index out of range. The bench drives inputs on the falling edge and holds them for one full cycle. It then compares `comOut` and `segOut` against its own pixel model at the next falling edge, which is half a cycle after the edge that takes the stimulus. The bench covers every valid and invalid address and every duty value, and it updates the model at the same edge it expects the design to.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  parameter int NUM_ROWS     = 4;
  parameter int SEGS_PER_ROW = 8;
  parameter int NUM_COMS     = 4;
  parameter int ADDR_W       = 4;
  parameter int ROW_BASE     = 12;  // must be a multiple of NUM_ROWS
  parameter int COL_BASE     = 8;   // must be a multiple of SEGS_PER_ROW
  parameter int NUM_SEGS     = NUM_ROWS * SEGS_PER_ROW;
  parameter int ROW_IDX_W    = $clog2(NUM_ROWS);
  parameter int COL_IDX_W    = $clog2(SEGS_PER_ROW);
  parameter int SEG_W        = ROW_IDX_W + COL_IDX_W;
  parameter int COM_W        = $clog2(NUM_COMS);

  typedef struct packed {
    logic              wrHit;
    logic [SEG_W-1:0]  wrSeg;
    logic [COM_W-1:0]  comIdx;
    logic              comActive;
  } scan_ctl_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lcdTick,
  input  logic [COM_W-1:0]  dutySel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrRow,
  input  logic [ADDR_W-1:0] wrCol,
  output scan_ctl_t         ctl
);
  localparam logic [ADDR_W-1:0] RowLo = ADDR_W'(ROW_BASE);
  localparam logic [ADDR_W-1:0] ColLo = ADDR_W'(COL_BASE);

  logic [COM_W-1:0] comIdx;
  logic             rowOk, colOk;

  // Aligned bases: the upper address bits alone decide a hit.
  assign rowOk = (wrRow[ADDR_W-1:ROW_IDX_W] == RowLo[ADDR_W-1:ROW_IDX_W]);
  assign colOk = (wrCol[ADDR_W-1:COL_IDX_W] == ColLo[ADDR_W-1:COL_IDX_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      comIdx <= '0;
    end else if (lcdTick) begin
      if (comIdx >= dutySel) comIdx <= '0;
      else                   comIdx <= comIdx + COM_W'(1);
    end
  end

  always_comb begin
    ctl.wrHit     = wrEn && rowOk && colOk;
    ctl.wrSeg     = {wrRow[ROW_IDX_W-1:0], wrCol[COL_IDX_W-1:0]};
    ctl.comIdx    = comIdx;
    ctl.comActive = (comIdx <= dutySel);
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lcdTick && comIdx >= dutySel) |=> (comIdx == '0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lcdTick && comIdx < dutySel) |=> (comIdx == $past(comIdx) + COM_W'(1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lcdTick |=> $stable(comIdx));
endmodule

// File: rtl/lcd_scan_datapath.sv
module lcd_scan_datapath
  import lcd_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  scan_ctl_t           ctl,
  input  logic [NUM_COMS-1:0] wrData,
  output logic [NUM_COMS-1:0] comOut,
  output logic [NUM_SEGS-1:0] segOut
);
  logic [NUM_COMS-1:0] pixRam [NUM_SEGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEGS; i++) pixRam[i] <= '0;
    end else if (ctl.wrHit) begin
      pixRam[ctl.wrSeg] <= wrData;
    end
  end

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    assign segOut[s] = pixRam[s][ctl.comIdx];
  end

  for (genvar c = 0; c < NUM_COMS; c++) begin : g_com
    assign comOut[c] = ctl.comActive && (ctl.comIdx == COM_W'(c));
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comOut));

  assert_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrHit |=> (pixRam[$past(ctl.wrSeg)] == $past(wrData)));
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lcdTick,
  input  logic [COM_W-1:0]    dutySel,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrRow,
  input  logic [ADDR_W-1:0]   wrCol,
  input  logic [NUM_COMS-1:0] wrData,
  output logic [NUM_COMS-1:0] comOut,
  output logic [NUM_SEGS-1:0] segOut
);
  scan_ctl_t ctl;

  lcd_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lcdTick(lcdTick), .dutySel(dutySel),
    .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol), .ctl(ctl)
  );

  lcd_scan_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .comOut(comOut), .segOut(segOut)
  );

  logic addrOut;
  assign addrOut = (int'(wrRow) < ROW_BASE) || (int'(wrRow) >= ROW_BASE + NUM_ROWS) ||
                   (int'(wrCol) < COL_BASE) || (int'(wrCol) >= COL_BASE + SEGS_PER_ROW);

  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrOut && !lcdTick) |=> $stable(segOut));
endmodule

// File: tb/tb_lcd_scan_top.sv
module tb_lcd_scan_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lcdTick = 1'b0;
  logic [1:0]  dutySel = 2'd3;
  logic        wrEn = 1'b0;
  logic [3:0]  wrRow = '0, wrCol = '0, wrData = '0;
  logic [3:0]  comOut;
  logic [31:0] segOut;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] mem [32];
  int idx = 0;

  always #2 clk = ~clk;

  lcd_scan_top dut (.*);

  function automatic logic [31:0] expSeg();
    logic [31:0] v;
    for (int s = 0; s < 32; s++) v[s] = mem[s][idx];
    return v;
  endfunction

  function automatic logic [3:0] expCom();
    return (idx <= int'(dutySel)) ? 4'(1 << idx) : 4'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk(req, {28'd0, comOut}, {28'd0, expCom()});
    chk(req, segOut, expSeg());
  endtask

  task automatic doWrite(int r, int c, logic [3:0] d);
    wrEn = 1'b1; wrRow = 4'(r); wrCol = 4'(c); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (r >= 12 && c >= 8) mem[(r - 12) * 8 + (c - 8)] = d;
  endtask

  task automatic doTick();
    lcdTick = 1'b1;
    @(negedge clk);
    lcdTick = 1'b0;
    idx = (idx >= int'(dutySel)) ? 0 : idx + 1;
  endtask

  initial begin
    for (int s = 0; s < 32; s++) mem[s] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {28'd0, comOut}, 32'h1);
    chk("R1", segOut, 32'h0);
    for (int t = 0; t < 4; t++) begin doTick(); checkAll("R1"); end

    // R2/R3: fill every valid word
    for (int r = 12; r < 16; r++)
      for (int c = 8; c < 16; c++) begin
        doWrite(r, c, 4'(((r - 12) * 8 + (c - 8)) * 5 + 3));
        chk("R3", segOut, expSeg());
      end
    for (int t = 0; t < 4; t++) begin doTick(); checkAll("R2_R8"); end

    // R4: every invalid address, data all ones
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if (r < 12 || c < 8) begin
          doWrite(r, c, 4'hF);
          chk("R4", segOut, expSeg());
        end
    for (int t = 0; t < 4; t++) begin doTick(); checkAll("R4"); end

    // R5/R9: every duty, three frames each
    for (int d = 0; d < 4; d++) begin
      dutySel = 2'(d);
      for (int t = 0; t < 3 * (d + 1); t++) begin
        doTick();
        checkAll("R5");
        if ((t + 1) % (d + 1) == 0) chk("R9", {28'd0, comOut}, 32'h1);
      end
    end

    // R7: lower duty with index above new n
    dutySel = 2'd3;
    for (int t = 0; t < 3; t++) doTick();
    dutySel = 2'd1;
    @(negedge clk);
    chk("R7", {28'd0, comOut}, 32'h0);
    chk("R7", segOut, expSeg());
    doTick();
    checkAll("R5");
    chk("R5", {28'd0, comOut}, 32'h1);

    // R6: hold without tick
    repeat (10) @(negedge clk);
    checkAll("R6");

    // R3: overwrite clears pixels
    doWrite(12, 13, 4'h0);
    checkAll("R3");
    doWrite(15, 15, 4'hA);
    checkAll("R3");
    doTick(); checkAll("R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule